// File: doc/BRIEF.md
# Minifloat to Single-Precision Widener

This block takes an 8-bit minifloat and returns the same value as an IEEE 754 binary32 word. The input has a sign bit, a 4-bit biased exponent and a 3-bit significand. Every finite input value can be represented in binary32, so the conversion is always exact and the block has no rounding logic. Subnormal inputs are renormalised with a leading-zero count so that they leave as ordinary normal binary32 numbers. Signed zeros, infinities and NaNs are each carried over in their binary32 form.

Five class flags report what kind of input produced the word: zero, subnormal, normal, infinity or NaN. Exactly one flag is high at a time. A parameter chooses between a purely combinational path and a single output register. The register is the default, and it is what a datapath uses when the widener sits between pipeline stages.

Top module: `mf8_to_f32_widen`

## Requirements
- R1: Input bit 7 is the sign, bits 6:3 are the exponent field e and bits 2:0 are the significand m, with exponent bias 7. For e in 1..14, the output is {sign, 8-bit exponent e+120, fraction with m in bits 22:20 and zeros below}.
- R2: For e = 0 and m ≠ 0 (value 0.m × 2^-6), let z be the number of leading zeros of m. The output exponent is 120 − z. The fraction holds the bits of m below its leading one, left-justified from bit 22, with zeros below.
- R3: For e = 0 and m = 0, the output is a binary32 zero whose bit 31 equals the input sign and whose bits 30:0 are all zero, so −0 gives 0x80000000.
- R4: For e = 15 and m = 0, the output is an infinity of the input sign: exponent 0xFF and fraction 0.
- R5: For e = 15 and m ≠ 0, the output is a quiet NaN. It keeps the input sign, has exponent 0xFF and fraction bit 22 set, carries m in fraction bits 21:19 and has zeros below.
- R6: The flags is_zero_o, is_sub_o, is_norm_o, is_inf_o and is_nan_o follow the classes of R1–R5, and exactly one of them is high in every cycle.
- R7: Boundary values are exact. 0x01 gives 0x3B000000 (0.001953125), 0x07 gives 0x3C600000 (0.013671875), 0x08 gives 0x3C800000 (0.015625), 0x38 gives 0x3F800000 (1.0) and 0x77 gives 0x43700000 (240).
- R8: With OUT_REG = 1, each output shows the conversion of the input sampled at the previous rising clock edge. While rst_n is low, the outputs hold +0 (0x00000000) with only is_zero_o high.
- R9: Of the 256 input codes, exactly 14 raise is_nan_o and the other 242 do not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| mf_i | input | 8 | Minifloat input {sign, exponent, significand} |
| f32_o | output | 32 | binary32 result |
| is_zero_o | output | 1 | Input is a signed zero |
| is_sub_o | output | 1 | Input is subnormal |
| is_norm_o | output | 1 | Input is normal |
| is_inf_o | output | 1 | Input is an infinity |
| is_nan_o | output | 1 | Input is a NaN |

## Verification
Two things can fall in the same cycle. One is the release of reset. The other is the first conversion captured by the output register. The bench places a nonzero negative code on the input while reset is still low, confirms the +0 reset state, and then expects the very first edge after release to yield that code's conversion and class. In the random stream a new code arrives at every edge, so any slip in the register, or a stale class next to a fresh word, shows up as a mismatch against the bench's model. That model is built from real-valued arithmetic.

// File: rtl/mfw_pkg.sv
package mfw_pkg;
    localparam int MF_EXP_W = 4;
    localparam int MF_MAN_W = 3;
    localparam int MF_BIAS  = 7;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int SP_BIAS  = 127;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;

    typedef struct packed {
        logic zero;
        logic sub;
        logic norm;
        logic inf;
        logic nan;
    } mf_class_t;

    typedef struct packed {
        logic [SP_W-1:0] word;
        mf_class_t       cls;
    } widen_t;
endpackage

// File: rtl/mfw_classify.sv
module mfw_classify
    import mfw_pkg::*;
#(
    parameter int EXP_W = MF_EXP_W,
    parameter int MAN_W = MF_MAN_W
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] man_i,
    output mf_class_t        cls_o
);
    logic exp_min, exp_max, man_nz;

    always_comb begin
        exp_min    = (exp_i == '0);
        exp_max    = (exp_i == '1);
        man_nz     = (man_i != '0);
        cls_o.zero = exp_min & ~man_nz;
        cls_o.sub  = exp_min &  man_nz;
        cls_o.norm = ~exp_min & ~exp_max;
        cls_o.inf  = exp_max & ~man_nz;
        cls_o.nan  = exp_max &  man_nz;
    end
endmodule

// File: rtl/mfw_lzc.sv
module mfw_lzc #(
    parameter int W  = 3,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) cnt_o = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/mfw_assemble.sv
module mfw_assemble
    import mfw_pkg::*;
#(
    parameter int EXP_W = MF_EXP_W,
    parameter int MAN_W = MF_MAN_W,
    parameter int BIAS  = MF_BIAS,
    localparam int CW   = $clog2(MAN_W + 1)
) (
    input  logic             sign_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic [MAN_W-1:0] man_i,
    input  logic [CW-1:0]    lz_i,
    input  mf_class_t        cls_i,
    output logic [SP_W-1:0]  word_o
);
    localparam logic [SP_EXP_W-1:0] EXP_OFS = SP_EXP_W'(SP_BIAS - BIAS);
    localparam logic [SP_EXP_W-1:0] EXP_TOP = '1;

    logic [MAN_W:0]          shifted;
    logic [SP_EXP_W-1:0]     exp_out;
    logic [SP_MAN_W-1:0]     frac_out;

    always_comb begin
        shifted  = {1'b0, man_i} << (lz_i + 1'b1);
        exp_out  = '0;
        frac_out = '0;
        if (cls_i.norm) begin
            exp_out  = EXP_OFS + {{(SP_EXP_W-EXP_W){1'b0}}, exp_i};
            frac_out = {man_i, {(SP_MAN_W-MAN_W){1'b0}}};
        end else if (cls_i.sub) begin
            exp_out  = EXP_OFS - {{(SP_EXP_W-CW){1'b0}}, lz_i};
            frac_out = {shifted[MAN_W-1:0], {(SP_MAN_W-MAN_W){1'b0}}};
        end else if (cls_i.inf) begin
            exp_out  = EXP_TOP;
        end else if (cls_i.nan) begin
            exp_out  = EXP_TOP;
            frac_out = {1'b1, man_i, {(SP_MAN_W-MAN_W-1){1'b0}}};
        end
        word_o = {sign_i, exp_out, frac_out};
    end
endmodule

// File: rtl/mf8_to_f32_widen.sv
module mf8_to_f32_widen
    import mfw_pkg::*;
#(
    parameter int EXP_W   = MF_EXP_W,
    parameter int MAN_W   = MF_MAN_W,
    parameter int BIAS    = MF_BIAS,
    parameter bit OUT_REG = 1'b1,
    localparam int IN_W   = 1 + EXP_W + MAN_W,
    localparam int CW     = $clog2(MAN_W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] mf_i,
    output logic [SP_W-1:0] f32_o,
    output logic            is_zero_o,
    output logic            is_sub_o,
    output logic            is_norm_o,
    output logic            is_inf_o,
    output logic            is_nan_o
);
    localparam widen_t RST_VAL = '{word: '0, cls: '{zero: 1'b1, default: 1'b0}};

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic [CW-1:0]    lz;
    mf_class_t        cls;
    logic [SP_W-1:0]  word;
    widen_t           res_d, res_q;

    assign exp_f = mf_i[IN_W-2 -: EXP_W];
    assign man_f = mf_i[MAN_W-1:0];

    mfw_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
        .exp_i(exp_f), .man_i(man_f), .cls_o(cls)
    );

    mfw_lzc #(.W(MAN_W)) u_lzc (
        .vec_i(man_f), .cnt_o(lz)
    );

    mfw_assemble #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) u_asm (
        .sign_i(mf_i[IN_W-1]), .exp_i(exp_f), .man_i(man_f),
        .lz_i(lz), .cls_i(cls), .word_o(word)
    );

    always_comb begin
        res_d.word = word;
        res_d.cls  = cls;
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) res_q <= RST_VAL;
                else        res_q <= res_d;
            end

            // R8: registered sign follows the previous cycle's input sign
            a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (f32_o[SP_W-1] == $past(mf_i[IN_W-1])));
        end else begin : g_comb
            always_comb res_q = res_d;
        end
    endgenerate

    assign f32_o     = res_q.word;
    assign is_zero_o = res_q.cls.zero;
    assign is_sub_o  = res_q.cls.sub;
    assign is_norm_o = res_q.cls.norm;
    assign is_inf_o  = res_q.cls.inf;
    assign is_nan_o  = res_q.cls.nan;

    a_r6_one_class: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({is_zero_o, is_sub_o, is_norm_o, is_inf_o, is_nan_o}));
    a_r3_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
        is_zero_o |-> (f32_o[SP_W-2:0] == '0));
    a_r4_inf_shape: assert property (@(posedge clk) disable iff (!rst_n)
        is_inf_o |-> (f32_o[SP_W-2:0] == {{SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}}));
    a_r5_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        is_nan_o |-> (f32_o[SP_W-2 -: SP_EXP_W] == '1 && f32_o[SP_MAN_W-1]));
    a_r2_sub_is_normal: assert property (@(posedge clk) disable iff (!rst_n)
        is_sub_o |-> (f32_o[SP_W-2 -: SP_EXP_W] != '0 && f32_o[SP_W-2 -: SP_EXP_W] != '1));
endmodule

// File: tb/sim_mf8_to_f32_widen.sv
module sim_mf8_to_f32_widen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mf = 8'h00;
    logic [31:0] f32;
    logic        zr, sb, nm, nf, nn;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    mf8_to_f32_widen u0 (
        .clk(clk), .rst_n(rst_n), .mf_i(mf), .f32_o(f32),
        .is_zero_o(zr), .is_sub_o(sb), .is_norm_o(nm), .is_inf_o(nf), .is_nan_o(nn)
    );

    function automatic real pow2(int k);
        real p = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) p = p * 2.0;
        else        for (int i = 0; i < -k; i++) p = p / 2.0;
        return p;
    endfunction

    function automatic logic [31:0] ref_word(logic [7:0] c);
        logic s = c[7];
        int   e = int'(c[6:3]);
        int   m = int'(c[2:0]);
        real  v;
        logic [63:0] d;
        int   ex;
        if (e == 15) return (m == 0) ? {s, 8'hFF, 23'd0} : {s, 8'hFF, 1'b1, c[2:0], 19'd0};
        if (e == 0 && m == 0) return {s, 31'd0};
        if (e == 0) v = (real'(m) / 8.0) * pow2(-6);
        else        v = (1.0 + real'(m) / 8.0) * pow2(e - 7);
        d  = $realtobits(v);
        ex = int'(d[62:52]) - 1023 + 127;
        return {s, ex[7:0], d[51:29]};
    endfunction

    function automatic logic [4:0] ref_cls(logic [7:0] c);
        if (c[6:3] == 4'd0)  return (c[2:0] == 3'd0) ? 5'b10000 : 5'b01000;
        if (c[6:3] == 4'd15) return (c[2:0] == 3'd0) ? 5'b00010 : 5'b00001;
        return 5'b00100;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic chk_code(logic [7:0] c);
        logic [4:0] ec = ref_cls(c);
        string r = ec[4] ? "R3" : ec[3] ? "R2" : ec[2] ? "R1" : ec[1] ? "R4" : "R5";
        chk(r, f32, ref_word(c));
        chk("R6", {27'd0, zr, sb, nm, nf, nn}, {27'd0, ec});
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
        end
    end

    initial begin
        logic [7:0] prev;
        int nan_cnt = 0;
        void'($urandom(32'd2024));
        // R8: reset state while a nonzero code waits at the input
        mf = 8'h85;
        repeat (3) @(negedge clk);
        chk("R8", f32, 32'h0000_0000);
        chk("R8", {27'd0, zr, sb, nm, nf, nn}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: first edge after release converts the waiting code
        chk_code(8'h85);

        // exhaustive sweep, back to back, one cycle latency (R8, R9)
        prev = 8'h85;
        for (int i = 0; i < 256; i++) begin
            mf = 8'(i);
            @(negedge clk);
            chk_code(8'(i));
            if (nn) nan_cnt++;
        end
        chk("R9", 32'(nan_cnt), 32'd14);
        chk("R9", 32'(256 - nan_cnt), 32'd242);

        // R7: directed boundary values
        mf = 8'h01; @(negedge clk); chk("R7", f32, 32'h3B00_0000);
        mf = 8'h07; @(negedge clk); chk("R7", f32, 32'h3C60_0000);
        mf = 8'h08; @(negedge clk); chk("R7", f32, 32'h3C80_0000);
        mf = 8'h38; @(negedge clk); chk("R7", f32, 32'h3F80_0000);
        mf = 8'h77; @(negedge clk); chk("R7", f32, 32'h4370_0000);
        mf = 8'h80; @(negedge clk); chk("R3", f32, 32'h8000_0000);
        mf = 8'hF8; @(negedge clk); chk("R4", f32, 32'hFF80_0000);
        mf = 8'h7D; @(negedge clk); chk("R5", f32, 32'h7FE8_0000);

        // random stream, biased toward the exponent extremes
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] c = 8'($urandom);
            if (($urandom % 4) == 0) c[6:3] = (($urandom % 2) == 0) ? 4'd0 : 4'd15;
            mf = c;
            @(negedge clk);
            chk_code(c);
        end
        done = 1'b1;
        summary();
    end
endmodule